// File: doc/BRIEF.md
# Load-Linked Locking Coherence Line Controller

This block is the coherence controller for one line of a private data cache. It tracks the four usual stable states of a MESI protocol, three transient miss states, and two extra locked states. The core side presents one request per cycle: load, load-linked, store, instruction fetch, replacement or failed store-conditional. The network side presents snoops (forwarded reads, forwarded exclusive reads, forwarded instruction reads, invalidations) and responses (shared data, exclusive data, acknowledgements). The controller answers with miss requests, a hit strobe, and one stall signal for each of its two request queues.

A load-linked asks for exclusive ownership exactly as a store would. Once ownership is held, the line sits in a locked exclusive or locked modified state for a fixed number of cycles. During that window it refuses every snoop and every replacement, so a later store-conditional finds the line still owned. This stops many cores from repeatedly stealing the line from each other. When the window ends, the line drops back to plain exclusive or modified, and the stalled requests go through. A global enable input turns the feature off, and a load-linked then acts as an ordinary load.

The stall outputs and the strobes are combinational from the current state and the inputs of the same cycle. The state changes on the next rising clock edge.

Top module: `llsc_line_ctrl`

## Requirements
- R1: After synchronous reset, `line_state` is 0 (I), `locked` is low, and `core_stall`, `net_stall`, `core_hit`, `sc_fail`, `req_gets`, `req_getx` and `req_upgrade` are all low while the inputs are idle. The state codes are I=0, S=1, E=2, M=3, IS=4, IM=5, SM=6, LOCK_E=7, LOCK_M=8.
- R2: In I, an accepted load (op 0) or instruction fetch (op 3) raises `req_gets` and moves to IS. A load-linked (op 1) with `lock_en` high raises `req_getx`, not `req_gets`, and moves to IM with the miss marked as load-linked. A store (op 2) raises `req_getx` and moves to IM unmarked.
- R3: In S, a load-linked with `lock_en` high raises `req_upgrade` and moves to SM, marked. A store does the same, unmarked.
- R4: In E or M, a load-linked with `lock_en` high completes as a hit (`core_hit` high) and moves to LOCK_E or LOCK_M respectively.
- R5: When a miss in IM or SM completes, `core_hit` pulses. A marked miss enters LOCK_E, and an unmarked miss enters M. In IS, shared data (response kind 0) leads to S and exclusive data (kind 1) leads to E, both with a hit.
- R6: A data response in IM or SM carries `rsp_acks`, the number of acknowledgements (kind 2) still due. With zero the data completes the miss. Otherwise the acknowledgement that brings the outstanding count to zero completes it, and the earlier ones do not.
- R7: In LOCK_E or LOCK_M, every valid snoop raises `net_stall` and is not consumed: the state does not change because of it. Outside the locked states `net_stall` stays low.
- R8: In a locked state, a replacement (op 4) raises `core_stall`. A load, a load-linked or an instruction fetch hits and leaves the state unchanged. A store hits and moves the line to LOCK_M.
- R9: A locked period lasts exactly `LOCK_CYCLES` cycles (16 by default), counted from the cycle after entry. The line then returns to E from LOCK_E, or to M from LOCK_M. Repeated load-linked operations do not restart the period.
- R10: With `lock_en` low, a load-linked behaves exactly as a load: a GETS in I, and a plain hit with no state change in S, E or M.
- R11: A failed store-conditional (op 5) is accepted with `sc_fail` high in I, S, E, M, LOCK_E and LOCK_M. In IS, IM and SM it is stalled and `sc_fail` stays low.
- R12: In an unlocked stable state a valid snoop is consumed ahead of any core request in the same cycle, and that core request is stalled. A forwarded read or instruction read (kind 0 or 2) takes E, M or S to S. A forwarded exclusive read or an invalidation (kind 1 or 3) takes the line to I.
- R13: In IS, IM and SM every core request is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_en | input | 1 | Enables load-linked locking |
| core_valid | input | 1 | Core request present |
| core_op | input | 3 | 0 load, 1 load-linked, 2 store, 3 ifetch, 4 replace, 5 SC fail |
| net_valid | input | 1 | Snoop present at head of network request queue |
| net_kind | input | 2 | 0 fwd read, 1 fwd exclusive, 2 fwd ifetch read, 3 invalidate |
| rsp_valid | input | 1 | Response present |
| rsp_kind | input | 2 | 0 shared data, 1 exclusive data, 2 ack |
| rsp_acks | input | ACK_W | Acks still due, carried with data |
| req_gets | output | 1 | Issue shared read miss |
| req_getx | output | 1 | Issue exclusive read miss |
| req_upgrade | output | 1 | Issue upgrade from S |
| core_hit | output | 1 | Core request completes this cycle |
| sc_fail | output | 1 | Failed store-conditional acknowledged |
| core_stall | output | 1 | Core request not taken this cycle |
| net_stall | output | 1 | Snoop held at queue head this cycle |
| line_state | output | 4 | Current state code |
| locked | output | 1 | Line is in a locked state |

## Verification
On every cycle the assertions check these properties: snoop stalling matches the locked state exactly; replacements and all transient-state requests are held; at most one miss request is issued; a locked run never exceeds `LOCK_CYCLES`; every unlock lands in E or M; and, in I, a load-linked picks GETX or GETS according to `lock_en`. Only the bench scenarios show the path-dependent outcomes. These are the completion of a miss on its last acknowledgement, a marked miss landing in LOCK_E against an unmarked one landing in M, the exact lock length, the snoop-over-core priority with its resulting state, and a store turning LOCK_E into LOCK_M.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [3:0] {
        ST_I  = 4'd0,
        ST_S  = 4'd1,
        ST_E  = 4'd2,
        ST_M  = 4'd3,
        ST_IS = 4'd4,
        ST_IM = 4'd5,
        ST_SM = 4'd6,
        ST_LE = 4'd7,
        ST_LM = 4'd8
    } line_st_t;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_LL     = 3'd1,
        OP_STORE  = 3'd2,
        OP_IFETCH = 3'd3,
        OP_REPL   = 3'd4,
        OP_SCFAIL = 3'd5
    } core_op_t;

    typedef enum logic [1:0] {
        SN_GETS = 2'd0,
        SN_GETX = 2'd1,
        SN_GETI = 2'd2,
        SN_INV  = 2'd3
    } snoop_t;

    typedef enum logic [1:0] {
        RS_DATA_S = 2'd0,
        RS_DATA_X = 2'd1,
        RS_ACK    = 2'd2
    } rsp_t;

    typedef struct packed {
        logic gets;
        logic getx;
        logic upgrade;
    } miss_req_t;

    function automatic logic is_transient(line_st_t s);
        return (s == ST_IS) || (s == ST_IM) || (s == ST_SM);
    endfunction

    function automatic logic is_locked(line_st_t s);
        return (s == ST_LE) || (s == ST_LM);
    endfunction

    function automatic line_st_t unlock_of(line_st_t s);
        case (s)
            ST_LE:   return ST_E;
            ST_LM:   return ST_M;
            default: return s;
        endcase
    endfunction

    function automatic logic snoop_keeps_copy(snoop_t k);
        return (k == SN_GETS) || (k == SN_GETI);
    endfunction

endpackage

// File: rtl/llsc_lock_timer.sv
module llsc_lock_timer
    import llsc_pkg::*;
#(
    parameter int LOCK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic fire
);
    localparam int TW = (LOCK_CYCLES < 2) ? 1 : $clog2(LOCK_CYCLES + 1);
    localparam logic [TW-1:0] RELOAD = TW'(LOCK_CYCLES - 1);

    logic [TW-1:0] remain;

    assign fire = active && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            remain <= '0;
        end else if (start) begin
            active <= 1'b1;
            remain <= RELOAD;
        end else if (fire) begin
            active <= 1'b0;
        end else if (active) begin
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/llsc_miss_tracker.sv
module llsc_miss_tracker
    import llsc_pkg::*;
#(
    parameter int ACK_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             alloc,
    input  logic             alloc_ll,
    input  logic             rsp_valid,
    input  rsp_t             rsp_kind,
    input  logic [ACK_W-1:0] rsp_acks,
    output logic             done,
    output logic             ll_mark
);
    logic             have_data;
    logic [ACK_W-1:0] owed;
    logic             mark_q;
    logic             got_data;
    logic             got_ack;

    assign got_data = busy && rsp_valid && (rsp_kind != RS_ACK) && !have_data;
    assign got_ack  = busy && rsp_valid && (rsp_kind == RS_ACK) && have_data;
    assign done     = (got_data && (rsp_acks == '0)) ||
                      (got_ack && (owed == ACK_W'(1)));
    assign ll_mark  = mark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_data <= 1'b0;
            owed      <= '0;
            mark_q    <= 1'b0;
        end else if (alloc) begin
            have_data <= 1'b0;
            owed      <= '0;
            mark_q    <= alloc_ll;
        end else if (done) begin
            have_data <= 1'b0;
            owed      <= '0;
            mark_q    <= 1'b0;
        end else if (got_data) begin
            have_data <= 1'b1;
            owed      <= rsp_acks;
        end else if (got_ack && (owed != '0)) begin
            owed      <= owed - 1'b1;
        end
    end

endmodule

// File: rtl/llsc_line_fsm.sv
module llsc_line_fsm
    import llsc_pkg::*;
(
    input  line_st_t  st,
    input  logic      lock_en,
    input  logic      core_valid,
    input  core_op_t  op,
    input  logic      net_valid,
    input  snoop_t    snoop,
    input  logic      rsp_valid,
    input  rsp_t      rsp_kind,
    input  logic      fill_done,
    input  logic      fill_ll,
    input  logic      timer_fire,
    output line_st_t  nxt,
    output logic      core_stall,
    output logic      net_stall,
    output logic      core_hit,
    output logic      sc_fail,
    output miss_req_t req,
    output logic      alloc,
    output logic      alloc_ll,
    output logic      timer_start
);
    logic trans;
    logic lockd;
    logic net_take;
    logic core_go;
    logic ll_eff;

    always_comb begin
        trans    = is_transient(st);
        lockd    = is_locked(st);
        net_take = net_valid && !lockd && !trans;
        ll_eff   = (op == OP_LL) && lock_en;

        net_stall  = net_valid && lockd;
        core_stall = core_valid &&
                     (trans || (lockd && (op == OP_REPL)) || net_take);
        core_go    = core_valid && !core_stall;

        nxt         = st;
        core_hit    = 1'b0;
        sc_fail     = 1'b0;
        req         = '0;
        alloc       = 1'b0;
        alloc_ll    = 1'b0;
        timer_start = 1'b0;

        if (trans) begin
            if (st == ST_IS) begin
                if (rsp_valid && (rsp_kind != RS_ACK)) begin
                    core_hit = 1'b1;
                    nxt = (rsp_kind == RS_DATA_X) ? ST_E : ST_S;
                end
            end else if (fill_done) begin
                core_hit = 1'b1;
                if (fill_ll) begin
                    nxt         = ST_LE;
                    timer_start = 1'b1;
                end else begin
                    nxt = ST_M;
                end
            end
        end else if (net_take) begin
            if (st != ST_I) begin
                nxt = snoop_keeps_copy(snoop) ? ST_S : ST_I;
            end
        end else if (core_go) begin
            case (op)
                OP_LL, OP_LOAD, OP_IFETCH: begin
                    if (op == OP_LL && ll_eff) begin
                        case (st)
                            ST_I: begin
                                nxt = ST_IM; req.getx = 1'b1;
                                alloc = 1'b1; alloc_ll = 1'b1;
                            end
                            ST_S: begin
                                nxt = ST_SM; req.upgrade = 1'b1;
                                alloc = 1'b1; alloc_ll = 1'b1;
                            end
                            ST_E: begin
                                nxt = ST_LE; core_hit = 1'b1; timer_start = 1'b1;
                            end
                            ST_M: begin
                                nxt = ST_LM; core_hit = 1'b1; timer_start = 1'b1;
                            end
                            default: core_hit = 1'b1;
                        endcase
                    end else if (st == ST_I) begin
                        nxt = ST_IS; req.gets = 1'b1;
                    end else begin
                        core_hit = 1'b1;
                    end
                end
                OP_STORE: begin
                    case (st)
                        ST_I: begin
                            nxt = ST_IM; req.getx = 1'b1; alloc = 1'b1;
                        end
                        ST_S: begin
                            nxt = ST_SM; req.upgrade = 1'b1; alloc = 1'b1;
                        end
                        ST_E, ST_M: begin
                            nxt = ST_M; core_hit = 1'b1;
                        end
                        default: begin
                            nxt = ST_LM; core_hit = 1'b1;
                        end
                    endcase
                end
                OP_REPL:   nxt = ST_I;
                OP_SCFAIL: sc_fail = 1'b1;
                default:   nxt = st;
            endcase
        end

        if (timer_fire) begin
            nxt = unlock_of(nxt);
        end
    end

endmodule

// File: rtl/llsc_line_ctrl.sv
module llsc_line_ctrl
    import llsc_pkg::*;
#(
    parameter int LOCK_CYCLES = 16,
    parameter int ACK_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_en,
    input  logic             core_valid,
    input  logic [2:0]       core_op,
    input  logic             net_valid,
    input  logic [1:0]       net_kind,
    input  logic             rsp_valid,
    input  logic [1:0]       rsp_kind,
    input  logic [ACK_W-1:0] rsp_acks,
    output logic             req_gets,
    output logic             req_getx,
    output logic             req_upgrade,
    output logic             core_hit,
    output logic             sc_fail,
    output logic             core_stall,
    output logic             net_stall,
    output logic [3:0]       line_state,
    output logic             locked
);
    line_st_t  st_q;
    line_st_t  st_d;
    miss_req_t req;
    logic      busy;
    logic      alloc;
    logic      alloc_ll;
    logic      fill_done;
    logic      fill_ll;
    logic      t_start;
    logic      t_fire;
    logic      t_active;

    assign busy = (st_q == ST_IM) || (st_q == ST_SM);

    llsc_line_fsm u_fsm (
        .st          (st_q),
        .lock_en     (lock_en),
        .core_valid  (core_valid),
        .op          (core_op_t'(core_op)),
        .net_valid   (net_valid),
        .snoop       (snoop_t'(net_kind)),
        .rsp_valid   (rsp_valid),
        .rsp_kind    (rsp_t'(rsp_kind)),
        .fill_done   (fill_done),
        .fill_ll     (fill_ll),
        .timer_fire  (t_fire),
        .nxt         (st_d),
        .core_stall  (core_stall),
        .net_stall   (net_stall),
        .core_hit    (core_hit),
        .sc_fail     (sc_fail),
        .req         (req),
        .alloc       (alloc),
        .alloc_ll    (alloc_ll),
        .timer_start (t_start)
    );

    llsc_miss_tracker #(.ACK_W(ACK_W)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .alloc     (alloc),
        .alloc_ll  (alloc_ll),
        .rsp_valid (rsp_valid),
        .rsp_kind  (rsp_t'(rsp_kind)),
        .rsp_acks  (rsp_acks),
        .done      (fill_done),
        .ll_mark   (fill_ll)
    );

    llsc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .start  (t_start),
        .active (t_active),
        .fire   (t_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_I;
        else     st_q <= st_d;
    end

    assign req_gets    = req.gets;
    assign req_getx    = req.getx;
    assign req_upgrade = req.upgrade;
    assign line_state  = st_q;
    assign locked      = is_locked(st_q) && t_active;

endmodule

// File: rtl/llsc_line_ctrl_chk.sv
module llsc_line_ctrl_chk #(
    parameter int LOCK_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       lock_en,
    input logic       core_valid,
    input logic [2:0] core_op,
    input logic       net_valid,
    input logic       req_gets,
    input logic       req_getx,
    input logic       req_upgrade,
    input logic       sc_fail,
    input logic       core_stall,
    input logic       net_stall,
    input logic [3:0] line_state,
    input logic       locked
);
    logic [31:0] run_len;
    logic        in_trans;

    assign in_trans = (line_state == 4'd4) || (line_state == 4'd5) ||
                      (line_state == 4'd6);

    always_ff @(posedge clk) begin
        if (rst)         run_len <= '0;
        else if (locked) run_len <= run_len + 1;
        else             run_len <= '0;
    end

    p_snoop_held_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && net_valid) |-> net_stall);

    p_stall_only_locked_r7: assert property (@(posedge clk) disable iff (rst)
        net_stall |-> locked);

    p_repl_held_r8: assert property (@(posedge clk) disable iff (rst)
        (locked && core_valid && core_op == 3'd4) |-> core_stall);

    p_trans_held_r13: assert property (@(posedge clk) disable iff (rst)
        (in_trans && core_valid) |-> core_stall);

    p_one_miss_req_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_gets, req_getx, req_upgrade}));

    p_ll_getx_r2: assert property (@(posedge clk) disable iff (rst)
        (line_state == 4'd0 && core_valid && core_op == 3'd1 && lock_en && !net_valid)
        |-> (req_getx && !req_gets));

    p_ll_plain_r10: assert property (@(posedge clk) disable iff (rst)
        (line_state == 4'd0 && core_valid && core_op == 3'd1 && !lock_en && !net_valid)
        |-> (req_gets && !req_getx));

    p_lock_bound_r9: assert property (@(posedge clk) disable iff (rst)
        locked |-> (run_len < LOCK_CYCLES));

    p_unlock_dest_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> (line_state == 4'd2 || line_state == 4'd3));

    p_scfail_stable_r11: assert property (@(posedge clk) disable iff (rst)
        sc_fail |-> !in_trans);

endmodule

bind llsc_line_ctrl llsc_line_ctrl_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lock_en     (lock_en),
    .core_valid  (core_valid),
    .core_op     (core_op),
    .net_valid   (net_valid),
    .req_gets    (req_gets),
    .req_getx    (req_getx),
    .req_upgrade (req_upgrade),
    .sc_fail     (sc_fail),
    .core_stall  (core_stall),
    .net_stall   (net_stall),
    .line_state  (line_state),
    .locked      (locked)
);

// File: tb/sim_llsc_line_ctrl.sv
module sim_llsc_line_ctrl;
    localparam int L = 16;
    localparam int AW = 4;

    localparam logic [2:0] LD = 3'd0, LL = 3'd1, STO = 3'd2, RPL = 3'd4, SCF = 3'd5;
    localparam logic [1:0] NGETS = 2'd0, NGETX = 2'd1, NINV = 2'd3;
    localparam logic [1:0] DX = 2'd1, ACK = 2'd2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock_en = 1'b1;
    logic core_valid = 1'b0;
    logic [2:0] core_op = '0;
    logic net_valid = 1'b0;
    logic [1:0] net_kind = '0;
    logic rsp_valid = 1'b0;
    logic [1:0] rsp_kind = '0;
    logic [AW-1:0] rsp_acks = '0;
    logic req_gets, req_getx, req_upgrade, core_hit, sc_fail;
    logic core_stall, net_stall, locked;
    logic [3:0] line_state;

    int vecs = 0;
    int fails = 0;
    bit finished = 0;
    int c_hit, c_gets, c_getx, c_upg, c_sc, c_cst, c_nst;

    always #10 clk = ~clk;

    llsc_line_ctrl #(.LOCK_CYCLES(L), .ACK_W(AW)) u0 (
        .clk(clk), .rst(rst), .lock_en(lock_en),
        .core_valid(core_valid), .core_op(core_op),
        .net_valid(net_valid), .net_kind(net_kind),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_acks(rsp_acks),
        .req_gets(req_gets), .req_getx(req_getx), .req_upgrade(req_upgrade),
        .core_hit(core_hit), .sc_fail(sc_fail),
        .core_stall(core_stall), .net_stall(net_stall),
        .line_state(line_state), .locked(locked)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic cv, input logic [2:0] op,
                         input logic nv, input logic [1:0] nk,
                         input logic rv, input logic [1:0] rk,
                         input logic [AW-1:0] ra);
        @(negedge clk);
        core_valid = cv; core_op = op;
        net_valid = nv; net_kind = nk;
        rsp_valid = rv; rsp_kind = rk; rsp_acks = ra;
        #5;
        c_hit = core_hit; c_gets = req_gets; c_getx = req_getx;
        c_upg = req_upgrade; c_sc = sc_fail;
        c_cst = core_stall; c_nst = net_stall;
        @(posedge clk);
        #1;
        core_valid = 0; net_valid = 0; rsp_valid = 0;
    endtask

    task automatic core(input logic [2:0] op);
        drive(1, op, 0, 0, 0, 0, 0);
    endtask

    task automatic snoop(input logic [1:0] k);
        drive(0, 0, 1, k, 0, 0, 0);
    endtask

    task automatic rsp(input logic [1:0] k, input int a);
        drive(0, 0, 0, 0, 1, k, AW'(a));
    endtask

    task automatic wait_unlock(output int n);
        n = 0;
        while (locked && n < 200) begin
            n++;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic t_reset();
        #3;
        chk("R1 state", line_state, 0);
        chk("R1 locked", locked, 0);
        chk("R1 core_stall", core_stall, 0);
        chk("R1 net_stall", net_stall, 0);
        chk("R1 reqs", {req_gets, req_getx, req_upgrade, core_hit, sc_fail}, 0);
    endtask

    task automatic t_ll_miss();
        int n;
        core(LL);
        chk("R2 ll getx", c_getx, 1); chk("R2 ll no gets", c_gets, 0);
        chk("R2 state IM", line_state, 5);
        core(LD);
        chk("R13 load stalled in IM", c_cst, 1); chk("R13 state", line_state, 5);
        rsp(DX, 2);
        chk("R6 data with acks no hit", c_hit, 0); chk("R6 state", line_state, 5);
        rsp(ACK, 0);
        chk("R6 first ack no hit", c_hit, 0); chk("R6 state", line_state, 5);
        rsp(ACK, 0);
        chk("R6 last ack hit", c_hit, 1); chk("R5 marked to LOCK_E", line_state, 7);
        snoop(NGETX);
        chk("R7 getx stalled", c_nst, 1); chk("R7 state held", line_state, 7);
        core(RPL);
        chk("R8 replace stalled", c_cst, 1); chk("R8 state", line_state, 7);
        core(LD);
        chk("R8 load hit", c_hit, 1); chk("R8 state unchanged", line_state, 7);
        core(STO);
        chk("R8 store hit", c_hit, 1); chk("R8 to LOCK_M", line_state, 8);
        wait_unlock(n);
        chk("R9 back to M", line_state, 3);
        snoop(NGETX);
        chk("R12 getx taken", c_nst, 0); chk("R12 state I", line_state, 0);
    endtask

    task automatic t_lock_len();
        int n;
        core(LD);
        chk("R2 load gets", c_gets, 1); chk("R2 state IS", line_state, 4);
        rsp(DX, 0);
        chk("R5 IS fill hit", c_hit, 1); chk("R5 state E", line_state, 2);
        core(LL);
        chk("R4 E ll hit", c_hit, 1); chk("R4 state LOCK_E", line_state, 7);
        wait_unlock(n);
        chk("R9 lock length", n, L); chk("R9 back to E", line_state, 2);
        drive(1, LD, 1, NGETS, 0, 0, 0);
        chk("R12 core stalled", c_cst, 1); chk("R12 no hit", c_hit, 0);
        chk("R12 E to S", line_state, 1);
        core(LL);
        chk("R3 upgrade", c_upg, 1); chk("R3 state SM", line_state, 6);
        core(SCF);
        chk("R11 sc stalled SM", c_cst, 1); chk("R11 no sc_fail", c_sc, 0);
        rsp(DX, 0);
        chk("R5 grant hit", c_hit, 1); chk("R5 SM marked LOCK_E", line_state, 7);
        wait_unlock(n);
        chk("R9 unlock E", line_state, 2);
    endtask

    task automatic t_store();
        int n;
        core(STO);
        chk("R5 E store hit", c_hit, 1); chk("R5 state M", line_state, 3);
        core(RPL);
        chk("R12 replace taken", c_cst, 0); chk("R12 state I", line_state, 0);
        core(STO);
        chk("R2 store getx", c_getx, 1); chk("R2 state IM", line_state, 5);
        rsp(DX, 0);
        chk("R5 store fill hit", c_hit, 1); chk("R5 unmarked to M", line_state, 3);
        core(LL);
        chk("R4 M ll hit", c_hit, 1); chk("R4 state LOCK_M", line_state, 8);
        core(SCF);
        chk("R11 sc accepted locked", c_sc, 1); chk("R11 no stall", c_cst, 0);
        snoop(NINV);
        chk("R7 inv stalled", c_nst, 1); chk("R7 state held", line_state, 8);
        wait_unlock(n);
        chk("R9 unlock M", line_state, 3);
        snoop(NINV);
        chk("R12 inv taken", c_nst, 0); chk("R12 inv to I", line_state, 0);
    endtask

    task automatic t_disabled();
        lock_en = 0;
        core(LL);
        chk("R10 ll gets", c_gets, 1); chk("R10 no getx", c_getx, 0);
        chk("R10 state IS", line_state, 4);
        rsp(DX, 0);
        chk("R10 state E", line_state, 2);
        core(LL);
        chk("R10 E ll hit", c_hit, 1); chk("R10 stays E", line_state, 2);
        chk("R10 not locked", locked, 0);
        snoop(NGETS);
        chk("R12 E gets to S", line_state, 1);
        core(LL);
        chk("R10 S ll hit", c_hit, 1); chk("R10 no upgrade", c_upg, 0);
        chk("R10 stays S", line_state, 1);
        core(SCF);
        chk("R11 sc in S", c_sc, 1);
        lock_en = 1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_ll_miss();
        t_lock_len();
        t_store();
        t_disabled();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vecs++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

endmodule